// File: doc/BRIEF.md
# Microprogrammed Control Sequencer with Opcode Mapping

This block is a small microprogrammed control unit. A 16-word by 8-bit control store, fixed in the design as a constant ROM, is addressed by a 4-bit microaddress register. Each microword drives three active-low indicator controls. It also decides where the sequencer goes next: either to the jump address held in the word, or to a start address mapped from a 2-bit opcode input.

After reset the unit runs a four-word fetch routine with every indicator dark. The last fetch word hands control to the mapped address. Opcode 00 is idle and lands back at the start of fetch. Opcodes 01, 10 and 11 each start their own four-step indicator routine, and the last word of that routine jumps back to fetch. The clock can be a single-step strobe, and the current microaddress is brought out so it can be observed.

Microword layout: bit 7 is the source select (0 = jump field, 1 = mapped opcode). Bit 6 drives z1_n, bit 5 drives z2_n and bit 4 drives z3_n. Bits 3:0 are the jump address. The layout places fetch at 0–3, the 01 routine at 4–7, the 10 routine at 8–11 and the 11 routine at 12–15. The mapped address is {opcode, 2'b00}.

Top module: `usq_sequencer`

## Requirements
- R1: When rst_n is low at a rising clock edge, uaddr becomes 0 after that edge, and all three indicator outputs are 1 (dark).
- R2: At addresses 0, 1 and 2 the next address is the current address plus one. At addresses 0 to 3 all of z1_n, z2_n and z3_n are 1.
- R3: At address 3 the next address is {opcode, 2'b00}, using the opcode present before that edge. Opcode 00 returns to address 0.
- R4: Opcode 01 routine (addresses 4–7): the lit indicators are Z2, then Z3, then Z1, then all three. An indicator is lit when its output is 0.
- R5: Opcode 10 routine (addresses 8–11): the lit indicators are Z1+Z3, then Z1+Z2, then Z2+Z3, then all three.
- R6: Opcode 11 routine (addresses 12–15): the lit indicators are all three, then Z1+Z2, then Z1 alone, then none.
- R7: The final word of each instruction routine (addresses 7, 11 and 15) jumps to address 0.
- R8: At every address other than 3, the opcode input has no effect on the next address. Inside a routine, addresses advance by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Step clock; the register loads on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 2 | Instruction code fed to the mapping logic |
| z1_n | output | 1 | Indicator Z1 control, active low |
| z2_n | output | 1 | Indicator Z2 control, active low |
| z3_n | output | 1 | Indicator Z3 control, active low |
| uaddr | output | 4 | Current microaddress |

## Verification
The indicator outputs are decoded combinationally from the current microaddress, so they are due in the same cycle the address is. A new address is due exactly one rising edge after the opcode and reset values that produced it. The bench drives the opcode and reset on the falling edge, advances its own address model at the rising edge, and compares both address and indicators on the next falling edge. Each result is therefore checked in the cycle it is due, never earlier or later. Random opcodes change every cycle, so the rule that the opcode matters only at address 3 is exercised all the time.

// File: rtl/usq_pkg.sv
// Package: shared widths, microword layout and the microcode generator.
// Assumes a 2-bit opcode and four-word routines laid out back to back.
package usq_pkg;
    localparam int OP_W    = 2;
    localparam int STEP_W  = 2;
    localparam int UA_W    = OP_W + STEP_W;
    localparam int DEPTH   = 1 << UA_W;
    localparam int LAMPS   = 3;
    localparam int WORD_W  = 1 + LAMPS + UA_W;

    // Microword fields, most significant first: source select, lamps, jump.
    typedef struct packed {
        logic              sel_map;
        logic [LAMPS-1:0]  lamp_n;   // {z1, z2, z3}, 0 lights
        logic [UA_W-1:0]   jump;
    } uword_t;

    // Lamp pattern (active low) for routine rt at step st.
    function automatic logic [LAMPS-1:0] lamp_pattern(input int rt, input int st);
        logic [LAMPS-1:0] p;
        p = '1;
        case (rt)
            1: case (st) 0: p = 3'b101; 1: p = 3'b110; 2: p = 3'b011; default: p = 3'b000; endcase
            2: case (st) 0: p = 3'b010; 1: p = 3'b001; 2: p = 3'b100; default: p = 3'b000; endcase
            3: case (st) 0: p = 3'b000; 1: p = 3'b001; 2: p = 3'b011; default: p = 3'b111; endcase
            default: p = 3'b111;
        endcase
        return p;
    endfunction

    // Build the microword stored at address a.
    function automatic uword_t ucode_word(input int a);
        uword_t w;
        int rt;
        int st;
        rt = a >> STEP_W;
        st = a % (1 << STEP_W);
        w.sel_map = (rt == 0) && (st == (1 << STEP_W) - 1);
        w.lamp_n  = lamp_pattern(rt, st);
        w.jump    = (st == (1 << STEP_W) - 1) ? '0 : UA_W'(a + 1);
        return w;
    endfunction
endpackage

// File: rtl/usq_ctrl_rom.sv
// Constant control store: one microword per address, filled from the
// package generator at elaboration. Read is purely combinational.
module usq_ctrl_rom
    import usq_pkg::*;
(
    input  logic [UA_W-1:0] addr,
    output uword_t          word
);
    uword_t rom [DEPTH];

    // Fill each ROM entry from the microcode generator.
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = ucode_word(i);
    end

    // Asynchronous read of the addressed word.
    always_comb word = rom[addr];
endmodule

// File: rtl/usq_next_addr.sv
// Next-address logic: selects the jump field or the mapped opcode start.
// Assumes every routine starts on a multiple of four.
module usq_next_addr
    import usq_pkg::*;
(
    input  uword_t          word,
    input  logic [OP_W-1:0] opcode,
    output logic [UA_W-1:0] next_addr
);
    logic [UA_W-1:0] mapped;

    // Mapping logic: opcode selects its routine base.
    always_comb mapped = {opcode, {STEP_W{1'b0}}};

    // Source multiplexer driven by the microword select bit.
    always_comb next_addr = word.sel_map ? mapped : word.jump;
endmodule

// File: rtl/usq_addr_reg.sv
// Microaddress register with synchronous active-low reset to zero.
module usq_addr_reg
    import usq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [UA_W-1:0] d,
    output logic [UA_W-1:0] q
);
    // Load the next address on every edge, or clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/usq_sequencer.sv
// Top: microaddress register, control ROM and next-address mux.
// Indicator outputs come straight from the current microword (active low).
module usq_sequencer
    import usq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      opcode,
    output logic            z1_n,
    output logic            z2_n,
    output logic            z3_n,
    output logic [3:0]      uaddr
);
    logic [UA_W-1:0] cur_addr;
    logic [UA_W-1:0] nxt_addr;
    uword_t          cur_word;

    usq_addr_reg u_reg (.clk(clk), .rst_n(rst_n), .d(nxt_addr), .q(cur_addr));
    usq_ctrl_rom u_rom (.addr(cur_addr), .word(cur_word));
    usq_next_addr u_nxt (.word(cur_word), .opcode(opcode), .next_addr(nxt_addr));

    // Drive the indicator controls and the observation port.
    always_comb begin
        z1_n  = cur_word.lamp_n[2];
        z2_n  = cur_word.lamp_n[1];
        z3_n  = cur_word.lamp_n[0];
        uaddr = cur_addr;
    end
endmodule

// File: rtl/usq_sequencer_chk.sv
// Checker for the sequencer ports; attached with bind below.
module usq_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] opcode,
    input logic       z1_n,
    input logic       z2_n,
    input logic       z3_n,
    input logic [3:0] uaddr
);
    logic rst_q;

    // Remember the reset level seen at the previous edge.
    always_ff @(posedge clk) rst_q <= rst_n;

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_q == 1'b0) |-> (uaddr == 4'd0 && z1_n && z2_n && z3_n)); // R1
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr < 4'd3) |=> (uaddr == $past(uaddr) + 4'd1)); // R2
    AST_FETCH_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr < 4'd4) |-> (z1_n && z2_n && z3_n)); // R2
    AST_MAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 4'd3) |=> (uaddr == {$past(opcode), 2'b00})); // R3
    AST_ROUTINE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr[1:0] == 2'b11 && uaddr != 4'd3) |=> (uaddr == 4'd0)); // R7
    AST_BODY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr >= 4'd4 && uaddr[1:0] != 2'b11) |=> (uaddr == $past(uaddr) + 4'd1)); // R8
endmodule

bind usq_sequencer usq_sequencer_chk u_chk (.*);

// File: tb/usq_sequencer_test.sv
// Bench: random opcodes from a fixed seed plus directed cases, with an
// independent address and indicator model checked on the falling edge.
module usq_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] opcode = 2'b00;
    logic       z1_n, z2_n, z3_n;
    logic [3:0] uaddr;

    int checks = 0;
    int errors = 0;
    logic [3:0] m_addr = 4'd0;

    usq_sequencer uut (.clk(clk), .rst_n(rst_n), .opcode(opcode),
                       .z1_n(z1_n), .z2_n(z2_n), .z3_n(z3_n), .uaddr(uaddr));

    always #10 clk = ~clk;

    // Expected lamps {z1,z2,z3}, active low, from the requirement tables.
    function automatic logic [2:0] exp_lamps(input logic [3:0] a);
        logic [2:0] lit;   // 1 = lit
        case (a)
            4:  lit = 3'b010;  5:  lit = 3'b001;  6:  lit = 3'b100;  7:  lit = 3'b111; // R4
            8:  lit = 3'b101;  9:  lit = 3'b110;  10: lit = 3'b011;  11: lit = 3'b111; // R5
            12: lit = 3'b111;  13: lit = 3'b110;  14: lit = 3'b100;  15: lit = 3'b000; // R6
            default: lit = 3'b000;                                                    // R2
        endcase
        return ~lit;
    endfunction

    function automatic logic [3:0] exp_next(input logic [3:0] a, input logic [1:0] op, input logic r);
        if (!r)                         return 4'd0;              // R1
        if (a == 4'd3)                  return {op, 2'b00};       // R3
        if (a[1:0] == 2'b11)            return 4'd0;              // R7
        return a + 4'd1;                                          // R2, R8
    endfunction

    function automatic string addr_tag(input logic [3:0] prev, input logic r);
        if (!r)                return "R1";
        if (prev == 4'd3)      return "R3";
        if (prev < 4'd3)       return "R2";
        if (prev[1:0] == 2'b11) return "R7";
        return "R8";
    endfunction

    function automatic string lamp_tag(input logic [3:0] a);
        if (a < 4)  return "R2";
        if (a < 8)  return "R4";
        if (a < 12) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock step: drive on the falling edge, update model, check after.
    task automatic step(input logic [1:0] op, input logic r);
        logic [3:0] prev;
        opcode = op;
        rst_n  = r;
        prev   = m_addr;
        @(posedge clk);
        m_addr = exp_next(prev, op, r);
        @(negedge clk);
        check(addr_tag(prev, r), "uaddr", uaddr, m_addr);
        check(r ? lamp_tag(m_addr) : "R1", "lamps", {z1_n, z2_n, z3_n}, exp_lamps(m_addr));
    endtask

    initial begin
        int seed;
        seed = 12345;
        void'($urandom(seed));
        @(negedge clk);
        step(2'b10, 1'b0);                 // R1 reset
        step(2'b11, 1'b0);
        // Directed: each opcode in turn, with the opcode held.
        for (int op = 0; op < 4; op++) begin
            for (int k = 0; k < 8; k++) step(op[1:0], 1'b1);
        end
        // Directed: opcode toggles except at the map cycle (R8).
        for (int k = 0; k < 24; k++) step(m_addr == 4'd3 ? 2'b01 : 2'(k), 1'b1);
        // Reset in the middle of a routine (R1).
        while (m_addr < 4'd4) step(2'b11, 1'b1);
        step(2'b11, 1'b0);
        // Random opcodes every cycle with occasional reset.
        for (int k = 0; k < 600; k++) begin
            step(2'($urandom), ($urandom % 50) != 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule